// File: doc/BRIEF.md
# Data-Bus IO Decoder with Guarded Program-Memory Write Port

This block sits on the load/store port of a Harvard-style core, between the core and its data RAM. Each access address is cut down to its low 17 bits. When bit 16 of that value is clear, the access passes straight through to a 64 KB data RAM in the same cycle, with its address aligned to the access size. When bit 16 is set, the access falls in an IO window and is served by a small set of device registers instead of RAM.

The IO window holds a console byte output, a debug word output, an exit register that raises a halt strobe carrying a core-supplied exit code, a readable timer that counts clock cycles divided by a fixed prescale, and a write path into program memory. Program memory can only be written by a three-step sequence: a key register that arms the path when it receives one magic word, an address register, and a data register whose write is forwarded as a program-memory store. Device outputs are registered strobes, one cycle wide.

Top module: `mmio_bus_decoder`

## Requirements
- R1: Only bits 16:0 of the request address are decoded. With bit 16 clear, a read or write drives the RAM strobe of the same kind in the same cycle, with `ram_addr_o` = aligned bits 15:0, `ram_size_o` = request size and `ram_wdata_o` = write data; a RAM read returns `ram_rdata_i` on `rsp_rdata_o` in that same cycle.
- R2: Size encoding is 0 = byte, 1 = halfword, 2 = word. A halfword clears address bit 0 and a word clears bits 1:0 on both the RAM address and the program-memory address; a byte keeps the address unchanged.
- R3: A write to 0x10000 produces, one clock later, a one-cycle `con_valid_o` pulse with `con_char_o` equal to write data bits 7:0.
- R4: A write to 0x1FC80 arms the program-memory path when the data equals 0x1337F7D1 and disarms it for any other value.
- R5: A write to 0x1FC84 loads the program-memory address register from write data bits 17:0.
- R6: A write to 0x1FC88 while armed produces, one clock later, a one-cycle `pm_wr_o` pulse with `pm_addr_o` = stored address aligned by the request size, `pm_size_o` = request size and `pm_wdata_o` = write data.
- R7: A write to 0x1FC88 while disarmed produces no `pm_wr_o` pulse.
- R8: A write to 0x1FFFC produces, one clock later, a one-cycle `halt_o` pulse with `halt_code_o` equal to `exit_code_i` of the request cycle.
- R9: A write to 0x1FFF8 produces, one clock later, a one-cycle `dbg_valid_o` pulse with `dbg_word_o` equal to the write data.
- R10: A read of 0x1FFF4 returns, in the same cycle, the number of rising clock edges since reset release divided by 100 (integer quotient), with no illegal flag.
- R11: Any other read in the IO window raises `rsp_illegal_o` in the same cycle with `rsp_rdata_o` = 0; no IO-window access ever drives a RAM strobe.
- R12: A write to any IO address other than the five device registers produces no strobe of any kind and no illegal flag.
- R13: After reset every output strobe is low and the program-memory path is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_rd_i | input | 1 | Core read request |
| req_wr_i | input | 1 | Core write request |
| req_addr_i | input | 32 | Core byte address |
| req_size_i | input | 2 | Access size: 0 byte, 1 half, 2 word |
| req_wdata_i | input | 32 | Core write data |
| exit_code_i | input | 32 | Exit code reported with a halt |
| rsp_rdata_o | output | 32 | Read data to the core |
| rsp_illegal_o | output | 1 | Illegal IO read flag |
| ram_rd_o | output | 1 | RAM read strobe |
| ram_wr_o | output | 1 | RAM write strobe |
| ram_addr_o | output | 16 | Aligned RAM byte address |
| ram_size_o | output | 2 | RAM access size |
| ram_wdata_o | output | 32 | RAM write data |
| ram_rdata_i | input | 32 | RAM read data |
| pm_wr_o | output | 1 | Program-memory write strobe |
| pm_addr_o | output | 18 | Aligned program-memory byte address |
| pm_size_o | output | 2 | Program-memory write size |
| pm_wdata_o | output | 32 | Program-memory write data |
| con_valid_o | output | 1 | Console character strobe |
| con_char_o | output | 8 | Console character |
| dbg_valid_o | output | 1 | Debug word strobe |
| dbg_word_o | output | 32 | Debug word |
| halt_o | output | 1 | Halt strobe |
| halt_code_o | output | 32 | Exit code with the halt |

## Verification
RAM pass-through, read data, the timer value and the illegal flag are all combinational in the request cycle, so the bench checks them a short delay after driving the request, before the next rising edge. Console, debug, halt and program-memory strobes leave a register and are due exactly one edge after the request; a behavioural model in the bench advances on the same edge and its expected strobes and payloads are compared with the outputs at every falling edge. The timer expectation comes from the bench's own count of rising edges since reset release, divided by 100.

// File: rtl/mmio_pkg.sv
package mmio_pkg;
  localparam int DEC_W = 17;
  localparam int RAM_AW = DEC_W - 1;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } size_e;

  localparam logic [DEC_W-1:0] IO_CONSOLE = 17'h10000;
  localparam logic [DEC_W-1:0] IO_PM_KEY  = 17'h1FC80;
  localparam logic [DEC_W-1:0] IO_PM_ADDR = 17'h1FC84;
  localparam logic [DEC_W-1:0] IO_PM_DATA = 17'h1FC88;
  localparam logic [DEC_W-1:0] IO_TIMER   = 17'h1FFF4;
  localparam logic [DEC_W-1:0] IO_DEBUG   = 17'h1FFF8;
  localparam logic [DEC_W-1:0] IO_EXIT    = 17'h1FFFC;

  localparam logic [31:0] PM_KEY_WORD = 32'h1337F7D1;
endpackage

// File: rtl/mmio_align.sv
module mmio_align
  import mmio_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] addr_i,
  input  size_e         size_i,
  output logic [AW-1:0] addr_o
);
  always_comb begin
    addr_o = addr_i;
    case (size_i)
      SZ_HALF: addr_o[0]   = 1'b0;
      SZ_WORD: addr_o[1:0] = 2'b00;
      default: addr_o      = addr_i;
    endcase
  end
endmodule

// File: rtl/mmio_cycle_timer.sv
module mmio_cycle_timer #(
  parameter int DW        = 32,
  parameter int CYCLE_DIV = 100
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [DW-1:0] ticks_o
);
  localparam int PRE_W = (CYCLE_DIV > 1) ? $clog2(CYCLE_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYCLE_DIV - 1);

  logic [PRE_W-1:0] pre_q;
  logic [DW-1:0]    ticks_q;

  // prescaler wraps every CYCLE_DIV edges; quotient advances on wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q   <= '0;
      ticks_q <= '0;
    end else if (pre_q == PRE_LAST) begin
      pre_q   <= '0;
      ticks_q <= ticks_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  assign ticks_o = ticks_q;
endmodule

// File: rtl/mmio_dev_regs.sv
module mmio_dev_regs
  import mmio_pkg::*;
#(
  parameter int DW    = 32,
  parameter int PM_AW = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             io_wr_i,
  input  logic [DEC_W-1:0] addr_i,
  input  size_e            size_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [DW-1:0]    exit_code_i,
  output logic             pm_wr_o,
  output logic [PM_AW-1:0] pm_addr_o,
  output logic [1:0]       pm_size_o,
  output logic [DW-1:0]    pm_wdata_o,
  output logic             con_valid_o,
  output logic [7:0]       con_char_o,
  output logic             dbg_valid_o,
  output logic [DW-1:0]    dbg_word_o,
  output logic             halt_o,
  output logic [DW-1:0]    halt_code_o
);
  logic             armed_q;
  logic [PM_AW-1:0] pm_base_q;
  logic [PM_AW-1:0] pm_base_al;

  logic hit_con, hit_key, hit_base, hit_data, hit_dbg, hit_exit;
  assign hit_con  = io_wr_i && (addr_i == IO_CONSOLE);
  assign hit_key  = io_wr_i && (addr_i == IO_PM_KEY);
  assign hit_base = io_wr_i && (addr_i == IO_PM_ADDR);
  assign hit_data = io_wr_i && (addr_i == IO_PM_DATA);
  assign hit_dbg  = io_wr_i && (addr_i == IO_DEBUG);
  assign hit_exit = io_wr_i && (addr_i == IO_EXIT);

  mmio_align #(.AW(PM_AW)) u_pm_align (
    .addr_i (pm_base_q),
    .size_i (size_i),
    .addr_o (pm_base_al)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q   <= 1'b0;
      pm_base_q <= '0;
    end else begin
      if (hit_key)  armed_q   <= (wdata_i == PM_KEY_WORD);
      if (hit_base) pm_base_q <= wdata_i[PM_AW-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      con_valid_o <= 1'b0;
      dbg_valid_o <= 1'b0;
      halt_o      <= 1'b0;
      pm_wr_o     <= 1'b0;
      con_char_o  <= '0;
      dbg_word_o  <= '0;
      halt_code_o <= '0;
      pm_addr_o   <= '0;
      pm_size_o   <= '0;
      pm_wdata_o  <= '0;
    end else begin
      con_valid_o <= hit_con;
      dbg_valid_o <= hit_dbg;
      halt_o      <= hit_exit;
      pm_wr_o     <= hit_data && armed_q;  // locked writes drop here
      if (hit_con)  con_char_o  <= wdata_i[7:0];
      if (hit_dbg)  dbg_word_o  <= wdata_i;
      if (hit_exit) halt_code_o <= exit_code_i;
      if (hit_data && armed_q) begin
        pm_addr_o  <= pm_base_al;
        pm_size_o  <= size_i;
        pm_wdata_o <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/mmio_bus_decoder.sv
module mmio_bus_decoder
  import mmio_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DW        = 32,
  parameter int PM_AW     = 18,
  parameter int CYCLE_DIV = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_rd_i,
  input  logic              req_wr_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_size_i,
  input  logic [DW-1:0]     req_wdata_i,
  input  logic [DW-1:0]     exit_code_i,
  output logic [DW-1:0]     rsp_rdata_o,
  output logic              rsp_illegal_o,
  output logic              ram_rd_o,
  output logic              ram_wr_o,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic [1:0]        ram_size_o,
  output logic [DW-1:0]     ram_wdata_o,
  input  logic [DW-1:0]     ram_rdata_i,
  output logic              pm_wr_o,
  output logic [PM_AW-1:0]  pm_addr_o,
  output logic [1:0]        pm_size_o,
  output logic [DW-1:0]     pm_wdata_o,
  output logic              con_valid_o,
  output logic [7:0]        con_char_o,
  output logic              dbg_valid_o,
  output logic [DW-1:0]     dbg_word_o,
  output logic              halt_o,
  output logic [DW-1:0]     halt_code_o
);
  logic [DEC_W-1:0] dec_addr;
  logic             io_sel;
  logic             timer_hit;
  logic [DW-1:0]    ticks;
  size_e            size;
  logic             unused_hi;

  assign dec_addr  = req_addr_i[DEC_W-1:0];
  assign unused_hi = ^req_addr_i[ADDR_W-1:DEC_W];
  assign io_sel    = dec_addr[DEC_W-1];
  assign timer_hit = io_sel && (dec_addr == IO_TIMER);
  assign size      = size_e'(req_size_i);

  // RAM pass-through
  mmio_align #(.AW(RAM_AW)) u_ram_align (
    .addr_i (dec_addr[RAM_AW-1:0]),
    .size_i (size),
    .addr_o (ram_addr_o)
  );

  assign ram_rd_o    = req_rd_i && !io_sel;
  assign ram_wr_o    = req_wr_i && !io_sel;
  assign ram_size_o  = req_size_i;
  assign ram_wdata_o = req_wdata_i;

  mmio_cycle_timer #(.DW(DW), .CYCLE_DIV(CYCLE_DIV)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ticks_o (ticks)
  );

  always_comb begin
    rsp_rdata_o   = '0;
    rsp_illegal_o = 1'b0;
    if (req_rd_i) begin
      if (!io_sel)        rsp_rdata_o   = ram_rdata_i;
      else if (timer_hit) rsp_rdata_o   = ticks;
      else                rsp_illegal_o = 1'b1;
    end
  end

  mmio_dev_regs #(.DW(DW), .PM_AW(PM_AW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .io_wr_i     (req_wr_i && io_sel),
    .addr_i      (dec_addr),
    .size_i      (size),
    .wdata_i     (req_wdata_i),
    .exit_code_i (exit_code_i),
    .pm_wr_o     (pm_wr_o),
    .pm_addr_o   (pm_addr_o),
    .pm_size_o   (pm_size_o),
    .pm_wdata_o  (pm_wdata_o),
    .con_valid_o (con_valid_o),
    .con_char_o  (con_char_o),
    .dbg_valid_o (dbg_valid_o),
    .dbg_word_o  (dbg_word_o),
    .halt_o      (halt_o),
    .halt_code_o (halt_code_o)
  );
endmodule

// File: rtl/mmio_bus_decoder_chk.sv
module mmio_bus_decoder_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rd_i,
  input logic        wr_i,
  input logic [16:0] addr_i,
  input logic [1:0]  size_i,
  input logic [31:0] exit_i,
  input logic        ram_rd_i,
  input logic        ram_wr_i,
  input logic [15:0] ram_addr_i,
  input logic        pm_wr_i,
  input logic        con_i,
  input logic        dbg_i,
  input logic        halt_i,
  input logic [31:0] halt_code_i,
  input logic        illegal_i
);
  assert_io_no_ram_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_i || wr_i) && addr_i[16]) |-> (!ram_rd_i && !ram_wr_i));

  assert_word_align_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ram_rd_i || ram_wr_i) && size_i == 2'd2) |-> (ram_addr_i[1:0] == 2'b00));

  assert_half_align_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ram_rd_i || ram_wr_i) && size_i == 2'd1) |-> !ram_addr_i[0]);

  assert_pm_source_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pm_wr_i |-> $past(wr_i && addr_i == 17'h1FC88));

  assert_con_source_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    con_i |-> $past(wr_i && addr_i == 17'h10000));

  assert_halt_code_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |-> (halt_code_i == $past(exit_i)));

  assert_illegal_read_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_i |-> (rd_i && addr_i[16]));

  assert_one_strobe_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pm_wr_i, con_i, dbg_i, halt_i}));

  assert_dbg_source_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_i |-> $past(wr_i && addr_i == 17'h1FFF8));
endmodule

bind mmio_bus_decoder mmio_bus_decoder_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_i        (req_rd_i),
  .wr_i        (req_wr_i),
  .addr_i      (req_addr_i[16:0]),
  .size_i      (req_size_i),
  .exit_i      (exit_code_i),
  .ram_rd_i    (ram_rd_o),
  .ram_wr_i    (ram_wr_o),
  .ram_addr_i  (ram_addr_o),
  .pm_wr_i     (pm_wr_o),
  .con_i       (con_valid_o),
  .dbg_i       (dbg_valid_o),
  .halt_i      (halt_o),
  .halt_code_i (halt_code_o),
  .illegal_i   (rsp_illegal_o)
);

// File: tb/mmio_bus_decoder_bench.sv
`timescale 1ns/1ps
module mmio_bus_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [31:0] addr = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0, exit_code = '0;
  logic [31:0] rdata;
  logic        illegal;
  logic        ram_rd, ram_wr;
  logic [15:0] ram_addr;
  logic [1:0]  ram_size;
  logic [31:0] ram_wdata, ram_rdata;
  logic        pm_wr;
  logic [17:0] pm_addr;
  logic [1:0]  pm_size;
  logic [31:0] pm_wdata;
  logic        con_v, dbg_v, halt;
  logic [7:0]  con_c;
  logic [31:0] dbg_w, halt_c;

  int n_cmp = 0, n_bad = 0;
  int edges = 0;

  always #4 clk = ~clk;

  assign ram_rdata = {ram_addr, 16'hA5C3};

  mmio_bus_decoder u_mmio_bus_decoder (
    .clk_i(clk), .rst_ni(rst_n), .req_rd_i(rd), .req_wr_i(wr),
    .req_addr_i(addr), .req_size_i(size), .req_wdata_i(wdata),
    .exit_code_i(exit_code), .rsp_rdata_o(rdata), .rsp_illegal_o(illegal),
    .ram_rd_o(ram_rd), .ram_wr_o(ram_wr), .ram_addr_o(ram_addr),
    .ram_size_o(ram_size), .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata),
    .pm_wr_o(pm_wr), .pm_addr_o(pm_addr), .pm_size_o(pm_size),
    .pm_wdata_o(pm_wdata), .con_valid_o(con_v), .con_char_o(con_c),
    .dbg_valid_o(dbg_v), .dbg_word_o(dbg_w), .halt_o(halt),
    .halt_code_o(halt_c)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] align_ref(input logic [31:0] a, input logic [1:0] s);
    if (s == 2'd1) return a & ~32'd1;
    if (s == 2'd2) return a & ~32'd3;
    return a;
  endfunction

  // behavioural reference for registered device outputs
  logic        m_armed, e_pm, e_con, e_dbg, e_halt;
  logic [31:0] m_base, e_pm_addr, e_pm_data, e_dbg_w, e_halt_c;
  logic [1:0]  e_pm_size;
  logic [7:0]  e_con_c;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_armed <= 0; m_base <= 0; e_pm <= 0; e_con <= 0; e_dbg <= 0; e_halt <= 0;
      e_pm_addr <= 0; e_pm_data <= 0; e_pm_size <= 0; e_con_c <= 0;
      e_dbg_w <= 0; e_halt_c <= 0; edges <= 0;
    end else begin
      int a;
      a = int'(addr & 32'h1FFFF);
      edges  <= edges + 1;
      e_con  <= wr && a == 'h10000;
      e_dbg  <= wr && a == 'h1FFF8;
      e_halt <= wr && a == 'h1FFFC;
      e_pm   <= wr && a == 'h1FC88 && m_armed;
      if (wr && a == 'h10000) e_con_c <= wdata[7:0];
      if (wr && a == 'h1FFF8) e_dbg_w <= wdata;
      if (wr && a == 'h1FFFC) e_halt_c <= exit_code;
      if (wr && a == 'h1FC80) m_armed <= (wdata == 32'h1337F7D1);
      if (wr && a == 'h1FC84) m_base <= wdata & 32'h3FFFF;
      if (wr && a == 'h1FC88 && m_armed) begin
        e_pm_addr <= align_ref(m_base, size);
        e_pm_size <= size;
        e_pm_data <= wdata;
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(e_con ? "R3 con" : "R12 con", {31'd0, con_v}, {31'd0, e_con});
    chk(e_pm ? "R6 pm" : "R7 pm", {31'd0, pm_wr}, {31'd0, e_pm});
    chk(e_dbg ? "R9 dbg" : "R12 dbg", {31'd0, dbg_v}, {31'd0, e_dbg});
    chk(e_halt ? "R8 halt" : "R12 halt", {31'd0, halt}, {31'd0, e_halt});
    if (e_con) chk("R3 char", {24'd0, con_c}, {24'd0, e_con_c});
    if (e_dbg) chk("R9 word", dbg_w, e_dbg_w);
    if (e_halt) chk("R8 code", halt_c, e_halt_c);
    if (e_pm) begin
      chk("R6 R5 pm addr", {14'd0, pm_addr}, e_pm_addr);
      chk("R6 pm size", {30'd0, pm_size}, {30'd0, e_pm_size});
      chk("R6 pm data", pm_wdata, e_pm_data);
    end
  end

  // drive at falling edge, check combinational response, hold one cycle
  task automatic access(input logic r, input logic w, input logic [31:0] a,
                        input logic [1:0] s, input logic [31:0] d);
    logic [16:0] m;
    @(negedge clk);
    rd = r; wr = w; addr = a; size = s; wdata = d;
    #1;
    m = a[16:0];
    if (!m[16]) begin
      chk("R1 ram_rd", {31'd0, ram_rd}, {31'd0, r});
      chk("R1 ram_wr", {31'd0, ram_wr}, {31'd0, w});
      chk("R2 ram_addr", {16'd0, ram_addr}, align_ref({16'd0, m[15:0]}, s) & 32'hFFFF);
      chk("R1 ram_size", {30'd0, ram_size}, {30'd0, s});
      if (w) chk("R1 ram_wdata", ram_wdata, d);
      if (r) chk("R1 rdata", rdata, {align_ref({16'd0, m[15:0]}, s)[15:0], 16'hA5C3});
    end else begin
      chk("R11 no ram", {30'd0, ram_rd, ram_wr}, 32'd0);
      if (r && m == 17'h1FFF4) begin
        chk("R10 timer", rdata, 32'(edges / 100));
        chk("R10 no illegal", {31'd0, illegal}, 32'd0);
      end else if (r) begin
        chk("R11 illegal", {31'd0, illegal}, 32'd1);
        chk("R11 rdata zero", rdata, 32'd0);
      end else begin
        chk("R12 no illegal", {31'd0, illegal}, 32'd0);
      end
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    rd = 0; wr = 0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R13 strobes", {28'd0, pm_wr, con_v, dbg_v, halt}, 32'd0);
    @(negedge clk) rst_n = 1'b1;

    // R1 / R2 RAM pass-through with high bits and odd addresses
    access(1, 0, 32'hFFFE_2347, 2'd0, 0);
    access(1, 0, 32'hFFFE_2347, 2'd1, 0);
    access(1, 0, 32'h0000_BEEF, 2'd2, 0);
    access(0, 1, 32'h1234_0005, 2'd2, 32'hCAFE_F00D);
    access(0, 1, 32'h0000_7FFF, 2'd1, 32'h0000_1111);
    // R3 console
    access(0, 1, 32'h0001_0000, 2'd0, 32'h1234_5641);
    access(0, 1, 32'hFFFF_0000, 2'd2, 32'h0000_007A);
    // R7 locked data write dropped
    access(0, 1, 32'h0001_FC84, 2'd2, 32'h0002_1237);
    access(0, 1, 32'h0001_FC88, 2'd2, 32'h5555_AAAA);
    // R4 wrong key keeps locked
    access(0, 1, 32'h0001_FC80, 2'd2, 32'h1337_F7D0);
    access(0, 1, 32'h0001_FC88, 2'd2, 32'h0000_0001);
    // R4 right key; R6 sizes
    access(0, 1, 32'h0001_FC80, 2'd2, 32'h1337_F7D1);
    access(0, 1, 32'h0001_FC88, 2'd2, 32'hDEAD_BEEF);
    access(0, 1, 32'h0001_FC88, 2'd1, 32'h0000_BEEF);
    access(0, 1, 32'h0001_FC88, 2'd0, 32'h0000_00EF);
    access(0, 1, 32'h0001_FC84, 2'd2, 32'hFFFF_FFFF);
    access(0, 1, 32'h0001_FC88, 2'd1, 32'h0000_0042);
    // R4 relock
    access(0, 1, 32'h0001_FC80, 2'd2, 32'h0000_0000);
    access(0, 1, 32'h0001_FC88, 2'd2, 32'h9999_9999);
    // R9 debug, R8 halt
    access(0, 1, 32'h0001_FFF8, 2'd2, 32'h0BAD_C0DE);
    exit_code = 32'h0000_0007;
    access(0, 1, 32'h0001_FFFC, 2'd2, 32'h0000_0000);
    exit_code = 32'hFFFF_FFFE;
    access(0, 1, 32'h0001_FFFC, 2'd2, 32'h1234_5678);
    // R12 unknown IO writes
    access(0, 1, 32'h0001_FFF0, 2'd2, 32'hFFFF_FFFF);
    access(0, 1, 32'h0001_0004, 2'd2, 32'h1337_F7D1);
    access(0, 1, 32'h0001_FFF4, 2'd2, 32'h0000_0001);
    // R11 illegal reads
    access(1, 0, 32'h0001_0000, 2'd2, 0);
    access(1, 0, 32'h0003_FC88, 2'd2, 0);
    // R10 timer at several points
    access(1, 0, 32'h0001_FFF4, 2'd2, 0);
    idle(150);
    access(1, 0, 32'h0001_FFF4, 2'd2, 0);
    idle(47);
    access(1, 0, 32'h0001_FFF4, 2'd2, 0);
    access(1, 0, 32'h0001_FFF4, 2'd2, 0);
    access(1, 0, 32'hFFFF_FFF4, 2'd2, 0);
    idle(120);
    access(1, 0, 32'h0001_FFF4, 2'd2, 0);
    idle(3);
    #1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule